// File: doc/BRIEF.md
# Exception Priority and Entry Controller

This block holds the status word of a processor core: the current status register and five saved copies, one for each privileged exception mode. Every cycle it samples seven exception request lines and picks one by a fixed priority, with IRQ and FIQ each subject to a mask bit in the status word. For the chosen request it performs entry in the following cycle. It raises a link-register write that carries the next-instruction address for the target mode, stores the current status word in that mode's saved slot, forces the mode and mask bits, and loads the PC with the vector.

Reset is sequenced separately. While the reset request is held, the block issues sequential word fetches. When reset is released, it performs a supervisor entry to address zero. A return request copies the current mode's saved status word back into the current one and redirects the PC to the link value minus an offset set by the exception kind. A plain software write of the status word is also accepted, at the lowest precedence. The banked general registers and instruction decode live elsewhere.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After `rst_n` is deasserted, `cpsr_o` reads 0x000000D3 (supervisor mode, I and F set, T clear), and `entry_o`, `pc_load_o` and `lr_we_o` are low.
- R2: Priority, highest first: data abort, FIQ, IRQ, prefetch abort, then undefined instruction or software interrupt. At most one entry occurs per cycle. A request that loses stays pending as long as its line is held. `cause_o` is 0 for data abort, 1 FIQ, 2 IRQ, 3 prefetch abort, 4 undefined, 5 software interrupt and 6 reset release.
- R3: An entry shows on the outputs one clock after the request is sampled, as a single-cycle `entry_o` pulse. In that same cycle `lr_we_o` is high, `lr_data_o` equals the sampled `next_addr`, and `lr_mode_o` gives the target mode.
- R4: Target mode and vector: data abort goes to abort mode (10111) at 0x10, FIQ to 10001 at 0x1C, IRQ to 10010 at 0x18, prefetch abort to 10111 at 0x0C, undefined to 11011 at 0x04, and software interrupt to supervisor (10011) at 0x08. `pc_load_o` is high and `vec_pc_o` holds the vector.
- R5: Every entry sets I (bit 7) and clears T (bit 5). FIQ entry and reset release also set F (bit 6); other entries leave F unchanged. Bits 31:8 keep their value.
- R6: An IRQ request while I=1, or an FIQ request while F=1, is ignored: there is no entry and the status word is unchanged.
- R7: On entry, the status word as it stood before the entry is stored in the target mode's saved slot. The slots are FIQ, IRQ, supervisor, abort and undefined.
- R8: While `req_rst` is high, every cycle shows `pc_load_o` high and no entry. The first such cycle gives `vec_pc_o` = `cur_pc`+4, and each following cycle adds 4. All other requests are ignored.
- R9: One clock after `req_rst` falls, the block enters supervisor mode: the low byte becomes 0xD3, the vector is 0, `lr_data_o` equals `cur_pc`, and the previous status word goes into the supervisor slot.
- R10: `ret_req` in FIQ, IRQ, supervisor, abort or undefined mode copies that mode's saved slot into the status word and loads `vec_pc_o` with `link_val` minus an offset. The offset is 4 for FIQ and IRQ, 8 for abort mode entered by data abort, 4 for abort mode entered by prefetch abort, and 0 for supervisor and undefined. In user (10000) or system mode, `ret_req` has no effect.
- R11: `cpsr_wr` loads all 32 bits of `cpsr_wdata` when no reset, entry or return acts in that cycle. Otherwise the write is dropped.
- R12: When an entry and a `ret_req` fall in the same cycle, the entry is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| req_rst | input | 1 | Core reset request (level) |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| cur_pc | input | PC_W | Current PC |
| next_addr | input | PC_W | Address of the next instruction |
| link_val | input | PC_W | Link register value of the current mode, used on return |
| ret_req | input | 1 | Return from exception |
| cpsr_wr | input | 1 | Software write of the status word |
| cpsr_wdata | input | 32 | Data for the software write |
| entry_o | output | 1 | Entry pulse |
| cause_o | output | 3 | Cause code of the entry |
| lr_we_o | output | 1 | Link register write strobe |
| lr_mode_o | output | 5 | Mode whose link register is written |
| lr_data_o | output | PC_W | Value written to the link register |
| pc_load_o | output | 1 | PC redirect strobe |
| vec_pc_o | output | PC_W | New PC value |
| cpsr_o | output | 32 | Current status word |

## Verification
Two pairs of functions can fall in the same cycle, and the bench provokes both by raising their inputs in one clock.

- **Entry against return, and entry against software write.** The bench raises an IRQ together with `ret_req`, and a data abort together with `cpsr_wr`. It judges the result by the surviving entry and by a status word that carries none of the dropped write's or return's effects.
- **Competing exceptions.** Data abort and FIQ are raised together, and so are IRQ, prefetch abort and undefined. The winner must enter first. Each loser, still held, must enter in the next cycle once the new mask bits allow it. The saved slots are then proven by unwinding the nest with returns, whose restored status words and offset PCs are compared.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int NSRC   = 6;
    localparam int SRC_W  = 3;
    localparam int NSLOT  = 5;
    localparam int SLOT_W = 3;

    localparam logic [SRC_W-1:0] SRC_DABT = 3'd0;
    localparam logic [SRC_W-1:0] SRC_FIQ  = 3'd1;
    localparam logic [SRC_W-1:0] SRC_IRQ  = 3'd2;
    localparam logic [SRC_W-1:0] SRC_PABT = 3'd3;
    localparam logic [SRC_W-1:0] SRC_UND  = 3'd4;
    localparam logic [SRC_W-1:0] SRC_SWI  = 3'd5;
    localparam logic [SRC_W-1:0] SRC_RST  = 3'd6;

    localparam int BIT_I = 7;
    localparam int BIT_F = 6;
    localparam int BIT_T = 5;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    localparam logic [31:0] CPSR_RST = 32'h0000_00D3;

    function automatic logic [4:0] src_mode(input logic [SRC_W-1:0] s);
        case (s)
            SRC_DABT: return M_ABT;
            SRC_FIQ:  return M_FIQ;
            SRC_IRQ:  return M_IRQ;
            SRC_PABT: return M_ABT;
            SRC_UND:  return M_UND;
            default:  return M_SVC;
        endcase
    endfunction

    function automatic logic [7:0] src_vec(input logic [SRC_W-1:0] s);
        case (s)
            SRC_DABT: return 8'h10;
            SRC_FIQ:  return 8'h1C;
            SRC_IRQ:  return 8'h18;
            SRC_PABT: return 8'h0C;
            SRC_UND:  return 8'h04;
            SRC_SWI:  return 8'h08;
            default:  return 8'h00;
        endcase
    endfunction

    // {valid, slot index}
    function automatic logic [SLOT_W:0] mode_slot(input logic [4:0] m);
        case (m)
            M_FIQ:   return {1'b1, 3'd0};
            M_IRQ:   return {1'b1, 3'd1};
            M_SVC:   return {1'b1, 3'd2};
            M_ABT:   return {1'b1, 3'd3};
            M_UND:   return {1'b1, 3'd4};
            default: return {1'b0, 3'd0};
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
    parameter int NSRC = 6,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  req,
    input  logic [NSRC-1:0]  mask,
    output logic             hit,
    output logic [SEL_W-1:0] sel
);
    // Index 0 is the highest priority; scan from the lowest so the last hit wins.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i] && !mask[i]) begin
                hit = 1'b1;
                sel = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/spsr_bank.sv
module spsr_bank #(
    parameter int NSLOT = 5,
    parameter int W     = 32,
    localparam int SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [W-1:0]     wdata,
    input  logic [SEL_W-1:0] rsel,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] slot_q [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[s] <= '0;
            end else if (we && (wsel == SEL_W'(s))) begin
                slot_q[s] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (rsel == SEL_W'(s)) rdata = slot_q[s];
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_rst,
    input  logic            req_dabt,
    input  logic            req_fiq,
    input  logic            req_irq,
    input  logic            req_pabt,
    input  logic            req_und,
    input  logic            req_swi,
    input  logic [PC_W-1:0] cur_pc,
    input  logic [PC_W-1:0] next_addr,
    input  logic [PC_W-1:0] link_val,
    input  logic            ret_req,
    input  logic            cpsr_wr,
    input  logic [31:0]     cpsr_wdata,
    output logic            entry_o,
    output logic [2:0]      cause_o,
    output logic            lr_we_o,
    output logic [4:0]      lr_mode_o,
    output logic [PC_W-1:0] lr_data_o,
    output logic            pc_load_o,
    output logic [PC_W-1:0] vec_pc_o,
    output logic [31:0]     cpsr_o
);
    localparam logic [PC_W-1:0] WORD = PC_W'(4);

    typedef struct packed {
        logic [31:0]      cpsr;
        logic [PC_W-1:0]  vec;
        logic [PC_W-1:0]  lr_data;
        logic [4:0]       lr_mode;
        logic [SRC_W-1:0] cause;
        logic             entry;
        logic             lr_we;
        logic             pc_load;
        logic             hold;
        logic             abt_data;
    } st_t;

    st_t st_q, st_d;

    logic [NSRC-1:0]   src_req, src_mask;
    logic              arb_hit;
    logic [SRC_W-1:0]  arb_sel;
    logic              spsr_we;
    logic [SLOT_W-1:0] spsr_wsel, spsr_rsel;
    logic [31:0]       spsr_rdata;
    logic [SLOT_W:0]   cur_slot, tgt_slot;

    logic              do_ent, tgt_f;
    logic [4:0]        tgt_mode;
    logic [PC_W-1:0]   tgt_vec, tgt_lr, ret_ofs;
    logic [SRC_W-1:0]  tgt_cause;

    assign src_req = {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt};

    always_comb begin
        src_mask = '0;
        src_mask[SRC_FIQ] = st_q.cpsr[BIT_F];
        src_mask[SRC_IRQ] = st_q.cpsr[BIT_I];
    end

    exc_arbiter #(.NSRC(NSRC)) u_arb (
        .req  (src_req),
        .mask (src_mask),
        .hit  (arb_hit),
        .sel  (arb_sel)
    );

    spsr_bank #(.NSLOT(NSLOT), .W(32)) u_spsr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (spsr_we),
        .wsel  (spsr_wsel),
        .wdata (st_q.cpsr),
        .rsel  (spsr_rsel),
        .rdata (spsr_rdata)
    );

    assign cur_slot  = mode_slot(st_q.cpsr[4:0]);
    assign spsr_rsel = cur_slot[SLOT_W-1:0];

    always_comb begin
        case (st_q.cpsr[4:0])
            M_FIQ, M_IRQ: ret_ofs = PC_W'(4);
            M_ABT:        ret_ofs = st_q.abt_data ? PC_W'(8) : PC_W'(4);
            default:      ret_ofs = '0;
        endcase
    end

    always_comb begin
        st_d         = st_q;
        st_d.entry   = 1'b0;
        st_d.lr_we   = 1'b0;
        st_d.pc_load = 1'b0;
        do_ent       = 1'b0;
        tgt_f        = 1'b0;
        tgt_mode     = M_SVC;
        tgt_vec      = '0;
        tgt_lr       = next_addr;
        tgt_cause    = SRC_RST;

        if (req_rst) begin
            st_d.hold    = 1'b1;
            st_d.pc_load = 1'b1;
            st_d.vec     = (st_q.hold ? st_q.vec : cur_pc) + WORD;
        end else if (st_q.hold) begin
            st_d.hold = 1'b0;
            do_ent    = 1'b1;
            tgt_f     = 1'b1;
            tgt_lr    = cur_pc;
        end else if (arb_hit) begin
            do_ent    = 1'b1;
            tgt_f     = (arb_sel == SRC_FIQ);
            tgt_mode  = src_mode(arb_sel);
            tgt_vec   = PC_W'(src_vec(arb_sel));
            tgt_cause = arb_sel;
        end else if (ret_req && cur_slot[SLOT_W]) begin
            st_d.cpsr    = spsr_rdata;
            st_d.pc_load = 1'b1;
            st_d.vec     = link_val - ret_ofs;
        end else if (cpsr_wr) begin
            st_d.cpsr = cpsr_wdata;
        end

        tgt_slot  = mode_slot(tgt_mode);
        spsr_we   = do_ent;
        spsr_wsel = tgt_slot[SLOT_W-1:0];

        if (do_ent) begin
            st_d.entry        = 1'b1;
            st_d.lr_we        = 1'b1;
            st_d.pc_load      = 1'b1;
            st_d.vec          = tgt_vec;
            st_d.lr_data      = tgt_lr;
            st_d.lr_mode      = tgt_mode;
            st_d.cause        = tgt_cause;
            st_d.cpsr[BIT_I]  = 1'b1;
            st_d.cpsr[BIT_F]  = st_q.cpsr[BIT_F] | tgt_f;
            st_d.cpsr[BIT_T]  = 1'b0;
            st_d.cpsr[4:0]    = tgt_mode;
            if (tgt_mode == M_ABT) st_d.abt_data = (tgt_cause == SRC_DABT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cpsr <= CPSR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign entry_o   = st_q.entry;
    assign cause_o   = st_q.cause;
    assign lr_we_o   = st_q.lr_we;
    assign lr_mode_o = st_q.lr_mode;
    assign lr_data_o = st_q.lr_data;
    assign pc_load_o = st_q.pc_load;
    assign vec_pc_o  = st_q.vec;
    assign cpsr_o    = st_q.cpsr;

    p_entry_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> (pc_load_o && lr_we_o && lr_mode_o == cpsr_o[4:0]));

    p_entry_mask_t_r5: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> (cpsr_o[BIT_I] && !cpsr_o[BIT_T]));

    p_entry_upper_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> (cpsr_o[31:8] == $past(cpsr_o[31:8])));

    p_fiq_sets_f_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_o && cpsr_o[4:0] == M_FIQ) |-> cpsr_o[BIT_F]);

    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpsr_o[BIT_I] && req_irq && !req_dabt && !req_fiq && !req_pabt
         && !req_und && !req_swi && !req_rst && !st_q.hold) |=> !entry_o);

    p_hold_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_rst |=> (pc_load_o && !entry_o));

    p_release_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && !req_rst) |=> (entry_o && vec_pc_o == '0 && cpsr_o[7:0] == 8'hD3));

endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        entry;
        logic        pc_load;
        logic        lr_we;
        logic [2:0]  cause;
        logic [4:0]  lr_mode;
        logic [31:0] lr_data;
        logic [31:0] vec;
        logic [31:0] cpsr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_rst = 1'b0;
    logic [5:0]  b_rq = '0;
    logic [31:0] b_cur = 32'h0000_1000;
    logic [31:0] b_nxt = 32'h0000_1004;
    logic [31:0] b_link = '0;
    logic        b_ret = 1'b0;
    logic        b_wr = 1'b0;
    logic [31:0] b_wd = '0;

    logic        entry_o, lr_we_o, pc_load_o;
    logic [2:0]  cause_o;
    logic [4:0]  lr_mode_o;
    logic [31:0] lr_data_o, vec_pc_o, cpsr_o;

    int   n_chk = 0;
    int   n_err = 0;
    exp_t q[$];

    logic [31:0] m_cpsr = 32'h0000_00D3;
    logic [31:0] m_spsr [5] = '{default: '0};
    logic [31:0] m_vec = '0;
    logic        m_hold = 1'b0;
    logic        m_abtd = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .req_rst(b_rst),
        .req_dabt(b_rq[0]), .req_fiq(b_rq[1]), .req_irq(b_rq[2]),
        .req_pabt(b_rq[3]), .req_und(b_rq[4]), .req_swi(b_rq[5]),
        .cur_pc(b_cur), .next_addr(b_nxt), .link_val(b_link),
        .ret_req(b_ret), .cpsr_wr(b_wr), .cpsr_wdata(b_wd),
        .entry_o(entry_o), .cause_o(cause_o), .lr_we_o(lr_we_o),
        .lr_mode_o(lr_mode_o), .lr_data_o(lr_data_o),
        .pc_load_o(pc_load_o), .vec_pc_o(vec_pc_o), .cpsr_o(cpsr_o)
    );

    function automatic logic [4:0] mode_tab(input int s);
        case (s)
            0: return 5'b10111;
            1: return 5'b10001;
            2: return 5'b10010;
            3: return 5'b10111;
            4: return 5'b11011;
            default: return 5'b10011;
        endcase
    endfunction

    function automatic logic [31:0] vec_tab(input int s);
        case (s)
            0: return 32'h10;
            1: return 32'h1C;
            2: return 32'h18;
            3: return 32'h0C;
            4: return 32'h04;
            default: return 32'h08;
        endcase
    endfunction

    function automatic int slot_of(input logic [4:0] m);
        case (m)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    task automatic enter(input int cause, input logic [31:0] lrd, inout exp_t e);
        logic [4:0] md;
        md = (cause == 6) ? 5'b10011 : mode_tab(cause);
        m_spsr[slot_of(md)] = m_cpsr;
        m_cpsr[7] = 1'b1;
        if (cause == 1 || cause == 6) m_cpsr[6] = 1'b1;
        m_cpsr[5] = 1'b0;
        m_cpsr[4:0] = md;
        if (md == 5'b10111) m_abtd = (cause == 0);
        m_vec     = (cause == 6) ? 32'h0 : vec_tab(cause);
        e.entry   = 1'b1;
        e.pc_load = 1'b1;
        e.lr_we   = 1'b1;
        e.cause   = 3'(cause);
        e.lr_mode = md;
        e.lr_data = lrd;
        e.vec     = m_vec;
    endtask

    // Drive one cycle of inputs and push the expected outputs for the following edge.
    task automatic step(input logic rs, input logic [5:0] rq, input logic rt,
                        input logic wr, input logic [31:0] wd, input string tag);
        exp_t e;
        int   pick;
        int   sl;
        logic [31:0] ofs;
        b_rst = rs; b_rq = rq; b_ret = rt; b_wr = wr; b_wd = wd;
        e.entry = 1'b0; e.pc_load = 1'b0; e.lr_we = 1'b0; e.cause = '0;
        e.lr_mode = '0; e.lr_data = '0; e.vec = '0; e.tag = tag;
        if (rs) begin
            m_vec = (m_hold ? m_vec : b_cur) + 32'd4;
            m_hold = 1'b1;
            e.pc_load = 1'b1;
            e.vec = m_vec;
        end else if (m_hold) begin
            m_hold = 1'b0;
            enter(6, b_cur, e);
        end else begin
            pick = -1;
            for (int i = 5; i >= 0; i--) begin
                if (rq[i] && !(i == 1 && m_cpsr[6]) && !(i == 2 && m_cpsr[7])) pick = i;
            end
            sl = slot_of(m_cpsr[4:0]);
            if (pick >= 0) begin
                enter(pick, b_nxt, e);
            end else if (rt && sl >= 0) begin
                case (m_cpsr[4:0])
                    5'b10001, 5'b10010: ofs = 32'd4;
                    5'b10111:           ofs = m_abtd ? 32'd8 : 32'd4;
                    default:            ofs = 32'd0;
                endcase
                m_cpsr = m_spsr[sl];
                m_vec = b_link - ofs;
                e.pc_load = 1'b1;
                e.vec = m_vec;
            end else if (wr) begin
                m_cpsr = wd;
            end
        end
        e.cpsr = m_cpsr;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 6'b0, 1'b0, 1'b0, 32'h0, tag);
    endtask

    task automatic ret(input logic [31:0] lk, input string tag);
        b_link = lk;
        step(1'b0, 6'b0, 1'b1, 1'b0, 32'h0, tag);
    endtask

    task automatic wr(input logic [31:0] d, input string tag);
        step(1'b0, 6'b0, 1'b0, 1'b1, d, tag);
    endtask

    // Monitor: compare one expected item per clock, away from the edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            logic bad;
            e = q.pop_front();
            n_chk++;
            bad = (entry_o !== e.entry) || (pc_load_o !== e.pc_load) ||
                  (lr_we_o !== e.lr_we) || (cpsr_o !== e.cpsr) ||
                  (e.pc_load && vec_pc_o !== e.vec) ||
                  (e.lr_we && (lr_mode_o !== e.lr_mode || lr_data_o !== e.lr_data)) ||
                  (e.entry && cause_o !== e.cause);
            if (bad) begin
                n_err++;
                $display("FAIL %s: act ent=%0b ld=%0b lrwe=%0b cause=%0d lrm=%b lrd=%h vec=%h cpsr=%h | exp ent=%0b ld=%0b lrwe=%0b cause=%0d lrm=%b lrd=%h vec=%h cpsr=%h",
                         e.tag, entry_o, pc_load_o, lr_we_o, cause_o, lr_mode_o, lr_data_o,
                         vec_pc_o, cpsr_o, e.entry, e.pc_load, e.lr_we, e.cause, e.lr_mode,
                         e.lr_data, e.vec, e.cpsr);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: act=timeout exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        n_chk++;
        if (cpsr_o !== 32'h0000_00D3 || entry_o !== 1'b0 || pc_load_o !== 1'b0 || lr_we_o !== 1'b0) begin
            n_err++;
            $display("FAIL R1 reset state: act cpsr=%h ent=%0b ld=%0b lrwe=%0b exp cpsr=000000d3 ent=0 ld=0 lrwe=0",
                     cpsr_o, entry_o, pc_load_o, lr_we_o);
        end
        @(negedge clk);

        wr(32'hA000_0010, "R11 write user status");
        b_nxt = 32'h0000_2004;
        step(0, 6'b000100, 0, 0, 0, "R3 R4 R5 R7 irq entry");
        step(0, 6'b000100, 0, 0, 0, "R6 irq masked by I");
        ret(32'h0000_2004, "R10 R7 return from irq");

        b_nxt = 32'h0000_3008;
        step(0, 6'b000011, 0, 0, 0, "R2 dabt beats fiq");
        b_nxt = 32'h0000_0014;
        step(0, 6'b000010, 0, 0, 0, "R2 R5 pending fiq enters");
        ret(32'h0000_0014, "R10 return fiq to abort");
        ret(32'h0000_3008, "R10 return abort offset 8");

        b_nxt = 32'h0000_4000;
        step(0, 6'b011100, 0, 0, 0, "R2 irq beats pabt und");
        step(0, 6'b011100, 0, 0, 0, "R2 pabt next");
        step(0, 6'b011100, 0, 0, 0, "R2 R4 und last");
        ret(32'h0000_0020, "R10 return und offset 0");
        ret(32'h0000_0020, "R10 return pabt offset 4");
        ret(32'h0000_0020, "R10 return irq offset 4");

        b_nxt = 32'h0000_5004;
        step(0, 6'b100000, 0, 0, 0, "R4 swi entry");
        ret(32'h0000_5004, "R10 return svc");

        wr(32'h4000_0050, "R11 write F set");
        step(0, 6'b000010, 0, 0, 0, "R6 fiq masked by F");
        step(0, 6'b000100, 0, 0, 0, "R5 irq keeps F");
        ret(32'h0000_6000, "R10 return irq");

        wr(32'h0000_0010, "R11 write user unmasked");
        step(0, 6'b000100, 1, 0, 0, "R12 irq beats return");
        ret(32'h0000_7000, "R12 later return");
        step(0, 6'b000001, 0, 1, 32'hFFFF_FFFF, "R11 write dropped on entry");
        ret(32'h0000_7008, "R10 abort return");
        ret(32'h0000_9999, "R10 return ignored in user");
        wr(32'h1234_561F, "R11 write system mode");
        ret(32'h0000_9999, "R10 return ignored in system");

        b_cur = 32'h0000_0200;
        step(1, 6'b0, 0, 0, 0, "R8 hold first");
        step(1, 6'b000101, 0, 0, 0, "R8 hold ignores requests");
        step(1, 6'b0, 0, 0, 0, "R8 hold third");
        idle("R9 release entry");
        ret(32'h0000_0040, "R9 R7 return restores pre-reset status");
        idle("R11 idle");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule